// File: doc/BRIEF.md
# Per-Bank First-Ready Request Scheduler

This block holds pending memory requests in one small age-ordered queue per bank. A request carries a bank number, a row address and a read/write flag. When the command stage asks for work on a bank, the block offers the oldest request that hits the row already open in that bank. If no request hits that row, it offers the oldest request in that bank's queue. In the same cycle the offered request is removed from its queue, wherever it sits.

Together with the request, the block gives a page-policy hint. In adaptive mode the hint keeps the row open when at least one other queued request in that bank targets the same row. When only the chosen request targets that row, the hint asks for a column command with autoprecharge. With adaptive mode off, a static policy input sets the hint directly.

All selection outputs are combinational from the queue state and the select inputs. Queue updates take effect at the next rising clock edge.

Top module: `frfcfs_bank_sched`

## Requirements
- R1: A request offered with `enq_valid` is appended at the young end of the queue for `enq_bank` when `enq_ready` is high. `enq_ready` is low exactly when that bank's queue already holds DEPTH entries, and a request offered while `enq_ready` is low is dropped.
- R2: When `sel_valid` is high, the bank's `open_valid` bit is set, and any queued entry's row equals that bank's `open_row` field (bits `b*ROW_W +: ROW_W`), the output is the oldest such matching entry.
- R3: When no queued entry matches, or the bank's `open_valid` bit is clear, the output is the oldest entry of the bank's queue.
- R4: With `adaptive_en` high, `out_keep_open` is 1 when two or more entries in the selected bank's queue have the chosen row (the chosen entry counts), and 0 when only the chosen entry has it.
- R5: With `adaptive_en` low, `out_keep_open` equals `static_open` (1 = plain column command, 0 = autoprecharge).
- R6: A selection removes exactly the chosen entry at the next clock edge. The remaining entries keep their relative age order.
- R7: `bank_nonempty[b]` is high exactly when bank b holds at least one entry. `out_valid` equals `sel_valid` AND `bank_nonempty[sel_bank]`. A select of an empty bank changes no state.
- R8: An enqueue and a removal on the same bank in the same cycle both take effect. The new entry becomes the youngest, and `enq_ready` is judged on the occupancy before the removal.
- R9: After reset every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New request present |
| enq_bank | input | BW | Bank of new request |
| enq_row | input | ROW_W | Row of new request |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_ready | output | 1 | Queue of `enq_bank` has room |
| open_valid | input | NBANK | Per-bank: a row is open |
| open_row | input | NBANK*ROW_W | Per-bank open row, bank b at `b*ROW_W` |
| adaptive_en | input | 1 | Adaptive page policy enable |
| static_open | input | 1 | Static policy: 1 keep open, 0 autoprecharge |
| sel_valid | input | 1 | Select-and-remove request |
| sel_bank | input | BW | Bank to select from |
| out_valid | output | 1 | Selection accepted; entry removed at the next edge |
| out_row | output | ROW_W | Row of chosen request |
| out_write | output | 1 | Type of chosen request |
| out_keep_open | output | 1 | Page hint for chosen request |
| bank_nonempty | output | NBANK | Per-bank not-empty flags |

## Verification
The stimulus uses only four row values, so each bank's queue regularly holds several entries with the same row. This exercises the first-ready pick at every queue position. Open-row valid bits and rows change every cycle, which separates the hit path (R2) from the oldest-entry fallback (R3) and from the case where no row is open. One bank receives extra traffic so that its queue fills and exercises back-pressure. Mid-queue removals, same-cycle enqueue with removal, and selects of empty banks also occur; wrong compaction or a lost entry shows up as a mismatch in a later cycle. The adaptive mode is switched on and off in long phases, and the static policy bit changes every cycle. This tells the hit-count hint apart from the static hint.

// File: rtl/frfcfs_bank_sched.sv
module frfcfs_bank_sched #(
  parameter int NBANK = 4,
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  localparam int BW = $clog2(NBANK),
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enq_valid,
  input  logic [BW-1:0]          enq_bank,
  input  logic [ROW_W-1:0]       enq_row,
  input  logic                   enq_write,
  output logic                   enq_ready,
  input  logic [NBANK-1:0]       open_valid,
  input  logic [NBANK*ROW_W-1:0] open_row,
  input  logic                   adaptive_en,
  input  logic                   static_open,
  input  logic                   sel_valid,
  input  logic [BW-1:0]          sel_bank,
  output logic                   out_valid,
  output logic [ROW_W-1:0]       out_row,
  output logic                   out_write,
  output logic                   out_keep_open,
  output logic [NBANK-1:0]       bank_nonempty
);

  logic [ROW_W-1:0] q_row [NBANK][DEPTH];
  logic             q_wr  [NBANK][DEPTH];
  logic [CW-1:0]    q_cnt [NBANK];

  logic [ROW_W-1:0] cur_open;
  logic             hit_found;
  logic [IW-1:0]    pick;
  logic [CW-1:0]    same_cnt;
  logic             enq_fire;
  logic             deq_b [NBANK];
  logic             enq_b [NBANK];
  logic [IW-1:0]    slot_b [NBANK];

  assign cur_open  = open_row[sel_bank*ROW_W +: ROW_W];
  assign enq_ready = q_cnt[enq_bank] < CW'(DEPTH);
  assign enq_fire  = enq_valid && enq_ready;
  assign out_valid = sel_valid && bank_nonempty[sel_bank];
  assign out_row   = q_row[sel_bank][pick];
  assign out_write = q_wr[sel_bank][pick];
  assign out_keep_open = adaptive_en ? (same_cnt > CW'(1)) : static_open;

  for (genvar b = 0; b < NBANK; b++) begin : g_flag
    assign bank_nonempty[b] = q_cnt[b] != '0;
  end

  always_comb begin
    hit_found = 1'b0;
    pick = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!hit_found && i < int'(q_cnt[sel_bank]) && open_valid[sel_bank]
          && q_row[sel_bank][i] == cur_open) begin
        hit_found = 1'b1;
        pick = IW'(i);
      end
  end

  always_comb begin
    same_cnt = '0;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(q_cnt[sel_bank]) && q_row[sel_bank][i] == out_row)
        same_cnt = same_cnt + CW'(1);
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      deq_b[b]  = out_valid && sel_bank == BW'(b);
      enq_b[b]  = enq_fire && enq_bank == BW'(b);
      slot_b[b] = deq_b[b] ? IW'(q_cnt[b] - CW'(1)) : IW'(q_cnt[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) q_cnt[b] <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (deq_b[b])
          for (int i = 0; i < DEPTH - 1; i++)
            if (i >= int'(pick)) begin
              q_row[b][i] <= q_row[b][i+1];
              q_wr[b][i]  <= q_wr[b][i+1];
            end
        if (enq_b[b]) begin
          q_row[b][slot_b[b]] <= enq_row;
          q_wr[b][slot_b[b]]  <= enq_write;
        end
        q_cnt[b] <= q_cnt[b] + CW'(enq_b[b]) - CW'(deq_b[b]);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> q_cnt[$past(enq_bank)] <= CW'(DEPTH)); // R1
  AST_ENQ_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire && !(out_valid && sel_bank == enq_bank)
    |=> q_cnt[$past(enq_bank)] == $past(q_cnt[enq_bank]) + CW'(1)); // R1
  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && hit_found |-> out_row == cur_open); // R2
  AST_LONE_ROW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && adaptive_en && q_cnt[sel_bank] == CW'(1) |-> !out_keep_open); // R4
  AST_DEQ_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(enq_fire && enq_bank == sel_bank)
    |=> q_cnt[$past(sel_bank)] == $past(q_cnt[sel_bank]) - CW'(1)); // R6
  AST_EMPTY_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && q_cnt[sel_bank] == '0 |-> !out_valid); // R7

endmodule

// File: tb/frfcfs_bank_sched_bench.sv
module frfcfs_bank_sched_bench;
  localparam int NB = 4, DP = 4, RW = 8;

  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, enq_write = 0, enq_ready;
  logic [1:0] enq_bank = 0, sel_bank = 0;
  logic [RW-1:0] enq_row = 0, out_row;
  logic [NB-1:0] open_valid = 0, bank_nonempty;
  logic [NB*RW-1:0] open_row = 0;
  logic adaptive_en = 0, static_open = 0, sel_valid = 0;
  logic out_valid, out_write, out_keep_open;

  frfcfs_bank_sched #(.NBANK(NB), .DEPTH(DP), .ROW_W(RW)) u_frfcfs_bank_sched (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
    .enq_row(enq_row), .enq_write(enq_write), .enq_ready(enq_ready),
    .open_valid(open_valid), .open_row(open_row), .adaptive_en(adaptive_en),
    .static_open(static_open), .sel_valid(sel_valid), .sel_bank(sel_bank),
    .out_valid(out_valid), .out_row(out_row), .out_write(out_write),
    .out_keep_open(out_keep_open), .bank_nonempty(bank_nonempty));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int mrow[NB][$];
  bit mwr[NB][$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int cyc);
    int eb, sb, idx, same, orow;
    bit hit, ev_ok;
    @(negedge clk);
    eb = ($urandom % 3 == 0) ? 0 : int'($urandom % NB);
    enq_valid = ($urandom % 10) < 6;
    enq_bank = 2'(eb);
    enq_row = RW'($urandom % 4);
    enq_write = 1'($urandom);
    sb = int'($urandom % NB);
    sel_valid = 1'($urandom);
    sel_bank = 2'(sb);
    open_valid = 4'($urandom | $urandom);
    for (int b = 0; b < NB; b++) open_row[b*RW +: RW] = RW'($urandom % 4);
    static_open = 1'($urandom);
    adaptive_en = ((cyc / 200) % 2) == 1;
    #1;
    for (int b = 0; b < NB; b++) chk("R7 nonempty", bank_nonempty[b], mrow[b].size() != 0);
    chk("R1 enq_ready", enq_ready, mrow[eb].size() < DP);
    chk("R7 out_valid", out_valid, sel_valid && mrow[sb].size() != 0);
    idx = 0; hit = 0; same = 0;
    if (sel_valid && mrow[sb].size() != 0) begin
      orow = int'(open_row[sb*RW +: RW]);
      for (int i = 0; i < mrow[sb].size(); i++)
        if (!hit && open_valid[sb] && mrow[sb][i] == orow) begin hit = 1; idx = i; end
      foreach (mrow[sb][i]) if (mrow[sb][i] == mrow[sb][idx]) same++;
      chk(hit ? "R2 R6 out_row" : "R3 R6 out_row", int'(out_row), mrow[sb][idx]);
      chk(hit ? "R2 R6 out_write" : "R3 R6 out_write", int'(out_write), int'(mwr[sb][idx]));
      if (adaptive_en) chk("R4 keep_open", out_keep_open, same > 1);
      else chk("R5 keep_open", out_keep_open, static_open);
    end
    // R8: readiness judged before removal; both updates applied
    ev_ok = enq_valid && mrow[eb].size() < DP;
    if (sel_valid && mrow[sb].size() != 0) begin
      mrow[sb].delete(idx);
      mwr[sb].delete(idx);
    end
    if (ev_ok) begin
      mrow[eb].push_back(int'(enq_row));
      mwr[eb].push_back(enq_write);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1 chk("R9 reset empty", int'(bank_nonempty), 0);
        for (int c = 0; c < 3000; c++) step(c);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule